// File: doc/BRIEF.md
# Channel Attention and Reset Sequencer

This block is the control front end that a host processor uses to wake up a command-driven coprocessor. It takes a raw reset request, a raw channel-attention strobe, a port strobe with a 32-bit data bus, and a raise-interrupt request. The reset request only counts once it has been seen high, after synchronization, for a minimum number of consecutive clocks. While a reset is in effect, the block forgets everything. Once the reset is released, it waits.

A channel attention is acted on when its synchronized level falls from high to low. The first attention after a reset produces a one-clock start-init pulse together with the start address. That address is a fixed default unless the host has completed a two-strobe pointer load through the port. Every later attention produces a one-clock start-command pulse and never re-initializes. The block also turns the raise-interrupt request into a single-clock pulse on an interrupt pin whose active level is selectable.

Top module: `attn_sequencer`

## Requirements
- R1: A raised host reset takes effect only after its synchronized level has stayed high for MIN_RST_CLKS (default 5) consecutive clocks. `rst_held_o` then stays high until the synchronized level drops. A request held for fewer clocks has no effect on the sequencing state.
- R2: A reset that takes effect re-arms initialization, so the next attention starts init. It also discards any port pointer, whether complete or half-loaded. A lone first strobe followed by a reset therefore does not pair with a strobe made after that reset.
- R3: No start pulse appears while the reset is in effect, including for attentions that fall during it. After release, nothing starts until an attention arrives.
- R4: Each high-to-low transition of `attn_i` gives exactly one start pulse, on the third rising clock edge after the input drops. A rising transition, or a held high level, gives none.
- R5: The first attention after a reset, with no valid pointer, pulses `init_start_o` with `start_addr_o` = 0x00FFFFF6.
- R6: The first attention after a reset, with a valid pointer, pulses `init_start_o` with `start_addr_o` equal to the data of the strobe that completed the load.
- R7: Every attention after the first pulses `cmd_start_o` and never `init_start_o`. The two pulses are never high together.
- R8: Each low-to-high transition of `port_stb_i` latches `port_data_i`. The pointer becomes valid on the second strobe of a pair. A third strobe opens a new pair and invalidates the pointer until the fourth.
- R9: A low-to-high transition of `irq_req_i` drives `irq_o` to its active level for exactly one clock, starting after the next clock edge. The active level is high when `irq_pol_i`=1 and low when `irq_pol_i`=0. At all other times `irq_o` sits at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| host_rst_i | input | 1 | Raw active-high host reset request (asynchronous) |
| attn_i | input | 1 | Raw channel-attention strobe (asynchronous) |
| port_stb_i | input | 1 | Port strobe, synchronous to clk, edge-acted |
| port_data_i | input | 32 | Data bus latched on each port strobe |
| irq_req_i | input | 1 | Raise-interrupt request, synchronous, edge-acted |
| irq_pol_i | input | 1 | Interrupt active level: 1 high, 0 low |
| rst_held_o | output | 1 | Qualified reset in effect |
| init_start_o | output | 1 | One-clock pulse: begin initialization |
| cmd_start_o | output | 1 | One-clock pulse: begin next command sequence |
| start_addr_o | output | 32 | Initialization start address, valid with init_start_o |
| irq_o | output | 1 | Interrupt pin, programmable polarity |

## Verification
A wrong sequencing state shows at the first attention after the fault: a start-command pulse appears where a start-init pulse was due, or the reverse, three clocks after `attn_i` falls. A wrong port phase or validity flag shows only when an initialization starts, as the default address where a loaded pointer was due, or the reverse. The bench therefore sweeps strobe counts from zero to four before each initialization. A miscounting reset qualifier shows on `rst_held_o` within a few clocks of the threshold, and one clock later in whether the next attention re-initializes.

// File: rtl/seq_pkg.sv
// Shared types for the attention sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package seq_pkg;
    typedef enum logic {
        SEQ_AWAIT_INIT = 1'b0,  // next attention starts initialization
        SEQ_RUN        = 1'b1   // next attention starts a command sequence
    } seq_state_t;
endpackage

// File: rtl/sync_chain.sv
// Multi-flop synchronizer for a single asynchronous bit.
// Assumes: STAGES >= 1; the output is reset to 0 by rst_n.
module sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first flop samples the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= 1'b0;
                else        stage_q[0] <= d_i;
            end
        end else begin : g_next
            // later flops shift the sampled value along
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rst_qualifier.sv
// Synchronizes the host reset request and asserts rst_held_o once the
// synchronized level has stayed high for MIN_CLKS consecutive clocks.
// Assumes: MIN_CLKS >= 1.
module rst_qualifier #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CLKS    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_raw_i,
    output logic rst_held_o
);
    localparam int CNT_W = $clog2(MIN_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_CLKS - 1);

    logic             rst_s;
    logic [CNT_W-1:0] run_cnt_q;

    sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rst_raw_i), .q_o(rst_s)
    );

    // count consecutive high clocks, saturating at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt_q  <= '0;
            rst_held_o <= 1'b0;
        end else begin
            if (!rst_s)                   run_cnt_q <= '0;
            else if (run_cnt_q != CNT_TOP) run_cnt_q <= run_cnt_q + 1'b1;
            rst_held_o <= rst_s && (run_cnt_q >= CNT_TOP);
        end
    end

    p_held_needs_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_held_o |-> $past(rst_s));
    p_held_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_s |=> !rst_held_o);
endmodule

// File: rtl/attn_detect.sv
// Synchronizes the channel-attention strobe and flags its falling edge
// for one clock.
// Assumes: the strobe stays high for at least one clock.
module attn_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic attn_raw_i,
    output logic attn_fall_o
);
    logic attn_s;
    logic attn_prev_q;

    sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(attn_raw_i), .q_o(attn_s)
    );

    // remember the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) attn_prev_q <= 1'b0;
        else        attn_prev_q <= attn_s;
    end

    assign attn_fall_o = attn_prev_q & ~attn_s;

    p_fall_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        attn_fall_o |=> !attn_fall_o);
endmodule

// File: rtl/port_latch.sv
// Two-strobe port: each rising strobe latches the data bus, and the
// second strobe of a pair marks the pointer valid.
// Assumes: port_stb_i is synchronous to clk; clr_i wins over a strobe.
module port_latch #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              stb_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] ptr_o,
    output logic              ptr_valid_o
);
    logic stb_prev_q;
    logic phase_q;      // 1 after the first strobe of a pair
    logic stb_rise;

    assign stb_rise = stb_i & ~stb_prev_q;

    // track the strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) stb_prev_q <= 1'b0;
        else        stb_prev_q <= stb_i;
    end

    // latch data and advance the pair phase on each strobe edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o       <= '0;
            phase_q     <= 1'b0;
            ptr_valid_o <= 1'b0;
        end else if (clr_i) begin
            phase_q     <= 1'b0;
            ptr_valid_o <= 1'b0;
        end else if (stb_rise) begin
            ptr_o       <= data_i;
            phase_q     <= ~phase_q;
            ptr_valid_o <= phase_q;
        end
    end

    p_valid_on_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ptr_valid_o) |-> $past(phase_q));
    p_clear_discards_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!ptr_valid_o && !phase_q));
endmodule

// File: rtl/irq_pulse.sv
// Turns a rising raise-interrupt request into a one-clock pulse on an
// interrupt pin whose active level follows pol_i.
// Assumes: req_i is synchronous; pol_i is static while a pulse is out.
module irq_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic pol_i,
    output logic irq_o
);
    logic req_prev_q;
    logic pulse_q;

    // register the request edge as a single-clock pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_prev_q <= 1'b0;
            pulse_q    <= 1'b0;
        end else begin
            req_prev_q <= req_i;
            pulse_q    <= req_i & ~req_prev_q;
        end
    end

    assign irq_o = pulse_q ? pol_i : ~pol_i;

    p_irq_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/attn_sequencer.sv
// Host control front end: qualifies reset, decides whether each channel
// attention starts initialization or a command sequence, supplies the
// init address and drives the interrupt pin.
// Assumes: port and interrupt inputs are synchronous; reset and attention
// inputs may be asynchronous.
module attn_sequencer
    import seq_pkg::*;
#(
    parameter int                 DATA_W       = 32,
    parameter int                 SYNC_STAGES  = 2,
    parameter int                 MIN_RST_CLKS = 5,
    parameter logic [DATA_W-1:0]  DEFAULT_ADDR = 'h00FF_FFF6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst_i,
    input  logic              attn_i,
    input  logic              port_stb_i,
    input  logic [DATA_W-1:0] port_data_i,
    input  logic              irq_req_i,
    input  logic              irq_pol_i,
    output logic              rst_held_o,
    output logic              init_start_o,
    output logic              cmd_start_o,
    output logic [DATA_W-1:0] start_addr_o,
    output logic              irq_o
);
    seq_state_t        seq_q;
    logic              attn_fall;
    logic [DATA_W-1:0] ptr;
    logic              ptr_valid;

    rst_qualifier #(.SYNC_STAGES(SYNC_STAGES), .MIN_CLKS(MIN_RST_CLKS)) u_rstq (
        .clk(clk), .rst_n(rst_n), .rst_raw_i(host_rst_i), .rst_held_o(rst_held_o)
    );

    attn_detect #(.SYNC_STAGES(SYNC_STAGES)) u_attn (
        .clk(clk), .rst_n(rst_n), .attn_raw_i(attn_i), .attn_fall_o(attn_fall)
    );

    port_latch #(.DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n), .clr_i(rst_held_o), .stb_i(port_stb_i),
        .data_i(port_data_i), .ptr_o(ptr), .ptr_valid_o(ptr_valid)
    );

    irq_pulse u_irq (
        .clk(clk), .rst_n(rst_n), .req_i(irq_req_i), .pol_i(irq_pol_i), .irq_o(irq_o)
    );

    // choose init or command start on each attention edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q        <= SEQ_AWAIT_INIT;
            init_start_o <= 1'b0;
            cmd_start_o  <= 1'b0;
            start_addr_o <= '0;
        end else begin
            init_start_o <= 1'b0;
            cmd_start_o  <= 1'b0;
            if (rst_held_o) begin
                seq_q <= SEQ_AWAIT_INIT;
            end else if (attn_fall) begin
                if (seq_q == SEQ_AWAIT_INIT) begin
                    init_start_o <= 1'b1;
                    start_addr_o <= ptr_valid ? ptr : DEFAULT_ADDR;
                    seq_q        <= SEQ_RUN;
                end else begin
                    cmd_start_o <= 1'b1;
                end
            end
        end
    end

    p_starts_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_start_o && cmd_start_o));
    p_no_reinit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SEQ_RUN && !rst_held_o) |=> !init_start_o);
    p_quiet_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_held_o |=> (!init_start_o && !cmd_start_o));
    p_reset_rearms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_held_o |=> (seq_q == SEQ_AWAIT_INIT));
    p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o |-> $stable(start_addr_o));
endmodule

// File: tb/attn_sequencer_tb.sv
`timescale 1ns/1ps
module attn_sequencer_tb;
    localparam logic [31:0] DEF = 32'h00FF_FFF6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rst_i = 1'b0;
    logic        attn_i = 1'b0;
    logic        port_stb_i = 1'b0;
    logic [31:0] port_data_i = '0;
    logic        irq_req_i = 1'b0;
    logic        irq_pol_i = 1'b1;
    logic        rst_held_o, init_start_o, cmd_start_o, irq_o;
    logic [31:0] start_addr_o;

    int checks = 0;
    int errors = 0;
    int n_init, n_cmd;
    logic [31:0] seen_addr;
    bit held_seen;

    always #2 clk = ~clk;

    attn_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .host_rst_i(host_rst_i), .attn_i(attn_i),
        .port_stb_i(port_stb_i), .port_data_i(port_data_i),
        .irq_req_i(irq_req_i), .irq_pol_i(irq_pol_i),
        .rst_held_o(rst_held_o), .init_start_o(init_start_o),
        .cmd_start_o(cmd_start_o), .start_addr_o(start_addr_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: rising edge, then sample point at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // watch outputs for n clocks, accumulating start pulses
    task automatic watch(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            if (init_start_o) begin n_init++; seen_addr = start_addr_o; end
            if (cmd_start_o) n_cmd++;
            if (rst_held_o) held_seen = 1'b1;
        end
    endtask

    task automatic host_reset(input int n);
        held_seen = 1'b0;
        host_rst_i = 1'b1;
        watch(n);
        host_rst_i = 1'b0;
        watch(6);
    endtask

    task automatic attention();
        n_init = 0; n_cmd = 0; seen_addr = 'x;
        attn_i = 1'b1;
        tick();
        attn_i = 1'b0;
        watch(6);
    endtask

    task automatic strobe(input logic [31:0] d);
        port_data_i = d;
        port_stb_i = 1'b1;
        tick();
        port_stb_i = 1'b0;
        tick();
    endtask

    function automatic logic [31:0] pdata(input int s, input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0101_0101 + 32'(s);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..R9 actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // reset state
        check("R3 reset init", {31'b0, init_start_o}, 0);
        check("R3 reset cmd", {31'b0, cmd_start_o}, 0);
        check("R1 reset held", {31'b0, rst_held_o}, 0);
        check("R9 reset irq idle", {31'b0, irq_o}, {31'b0, ~irq_pol_i});

        // R3: idle after release with no attention
        n_init = 0; n_cmd = 0;
        watch(10);
        check("R3 no start without attention", 32'(n_init + n_cmd), 0);

        // R4: exact latency, and no action on rise or held high
        attn_i = 1'b1;
        n_init = 0; n_cmd = 0;
        watch(5);
        check("R4 no start on rise/high", 32'(n_init + n_cmd), 0);
        attn_i = 1'b0;
        tick();
        tick();
        check("R4 no pulse after two edges", {31'b0, init_start_o}, 0);
        tick();
        check("R4 pulse on third edge", {31'b0, init_start_o}, 1);
        check("R5 power-on default addr", start_addr_o, DEF);
        tick();
        check("R4 pulse is one clock", {31'b0, init_start_o}, 0);

        // R1: sweep reset length; short ones must not re-arm
        for (int n = 1; n <= 8; n++) begin
            host_reset(n);
            check($sformatf("R1 held for len %0d", n), {31'b0, held_seen}, {31'b0, n >= 5});
            attention();
            if (n >= 5) begin
                check("R2 rearmed init", 32'(n_init), 1);
                check("R5 default addr", seen_addr, DEF);
                attention();
            end
            check($sformatf("R1 cmd after len %0d", n), 32'(n_cmd), 1);
            check("R7 no init when running", 32'(n_init), 0);
        end

        // R6/R8: sweep strobe count 0..4 before initialization
        for (int s = 0; s <= 4; s++) begin
            host_reset(6);
            for (int i = 0; i < s; i++) strobe(pdata(s, i));
            attention();
            check($sformatf("R8 init with %0d strobes", s), 32'(n_init), 1);
            check($sformatf("R6 addr with %0d strobes", s), seen_addr,
                  (s == 2 || s == 4) ? pdata(s, s - 1) : DEF);
            for (int k = 0; k < 2; k++) begin
                attention();
                check("R7 later attention cmd", 32'(n_cmd), 1);
                check("R7 later attention no init", 32'(n_init), 0);
            end
        end

        // R2: lone strobe then reset does not pair with a later strobe
        host_reset(6);
        strobe(32'hDEAD_0001);
        host_reset(6);
        strobe(32'hDEAD_0002);
        attention();
        check("R2 lone strobe discarded", seen_addr, DEF);

        // R2: complete pointer discarded by reset
        host_reset(6);
        strobe(32'hBEEF_0001);
        strobe(32'hBEEF_0002);
        host_reset(6);
        attention();
        check("R2 pointer discarded", seen_addr, DEF);

        // R3: attention during qualified reset is ignored
        n_init = 0; n_cmd = 0;
        host_rst_i = 1'b1;
        watch(7);
        attn_i = 1'b1;
        tick();
        attn_i = 1'b0;
        watch(6);
        host_rst_i = 1'b0;
        watch(6);
        check("R3 no start in reset", 32'(n_init + n_cmd), 0);
        attention();
        check("R3 init after release", 32'(n_init), 1);

        // R9: interrupt pulse, both polarities
        for (int p = 0; p <= 1; p++) begin
            irq_pol_i = p[0];
            tick();
            check("R9 idle level", {31'b0, irq_o}, {31'b0, ~p[0]});
            irq_req_i = 1'b1;
            tick();
            check("R9 active level", {31'b0, irq_o}, {31'b0, p[0]});
            tick();
            check("R9 one clock only", {31'b0, irq_o}, {31'b0, ~p[0]});
            irq_req_i = 1'b0;
            tick();
            check("R9 idle after", {31'b0, irq_o}, {31'b0, ~p[0]});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule